// File: doc/BRIEF.md
# Per-Phase Rising Zero-Crossing and Missing-Crossing Monitor

This block observes three signed filtered voltage sample streams, one per line phase, and flags each rising zero crossing. Every phase also owns a down-counting watchdog. A crossing on that phase rearms it. If the watchdog runs out, the phase has lost its line signal. A free-running prescaler shared by all lanes paces every watchdog, so the timeout window is expressed in prescaled ticks of the core clock.

Status is sticky. Crossing flags and timeout flags stay set until the host issues a clear strobe. An active-low interrupt request is the OR of all enabled flags. A per-phase select mask takes a phase out of service, and a deselected phase reports a permanent timeout.

Top module: `zc_timeout_monitor`

## Requirements
- R1: After reset every crossing flag and every timeout flag of a selected phase reads 0, and `irq_n` reads 1.
- R2: A selected phase records a crossing only when a valid sample is non-negative and the previous valid sample of that phase was negative (two's complement sign bit set). Every other pair of consecutive samples leaves the flag clear.
- R3: While a phase's bit in `phase_sel` is 0, its crossing flag is never set and its timeout flag reads 1. The forced flag is not affected by a clear.
- R4: After a crossing loads the reload value N, the phase's timeout flag sets within N×PRESCALE+1 cycles, and not before (N−1)×PRESCALE+1 cycles, if no further crossing arrives.
- R5: After a timeout the counter stays at zero. A clear then leaves the timeout flag at 0 until a new crossing reloads the counter and it expires again.
- R6: Each crossing on a selected phase reloads that phase's counter from `tmo_reload`. Crossings spaced closer than the window therefore never produce a timeout.
- R7: A one-cycle `stat_clr` clears all sticky flags. A flag event in the same cycle as the clear wins, and that flag is left set.
- R8: `irq_n` is 0 exactly when some flag is 1 and its enable is 1. Enable bit k (k < 3) gates the timeout flag of phase k, and bit 3+k gates the crossing flag of phase k.
- R9: Each watchdog counter starts at all ones after reset. With the default width, no timeout appears for at least 65535 prescaled ticks without a crossing.
- R10: The watchdog counters advance only on the shared prescaler tick, which fires once every PRESCALE clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Strobe qualifying all three samples |
| sample_bus | input | NUM_PHASE*SAMPLE_W | Signed samples, phase k at bits [k*SAMPLE_W +: SAMPLE_W] |
| phase_sel | input | NUM_PHASE | Per-phase enable for detection |
| tmo_reload | input | TMO_W | Watchdog reload value in prescaled ticks |
| irq_en | input | 2*NUM_PHASE | Interrupt enables: timeout bits low, crossing bits high |
| stat_clr | input | 1 | Clear strobe for all sticky flags |
| zc_flag | output | NUM_PHASE | Sticky rising-crossing flag per phase |
| tmo_flag | output | NUM_PHASE | Sticky timeout flag per phase, forced 1 when deselected |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
On every cycle the assertions check the following:
- the prescaler tick spacing;
- that a timeout only rises with its counter at zero;
- that a counter parked at zero stays there unless reloaded;
- that a clear without a coincident event empties the flags;
- that a new crossing always leaves the counter holding the reload value;
- that the interrupt stays quiet while all enables are low.

Some behaviours depend on whole sample sequences and timing windows, and only the bench scenarios show them. These are the exact sign-pair rule across all boundary values, the bounds of the timeout window, rearming by repeated crossings, no refiring after clear, and the exact bit mapping of the interrupt enables.

// File: rtl/zcm_pkg.sv
package zcm_pkg;
   // sticky flag pair kept by every phase lane
   typedef struct packed {
      logic zc;
      logic tmo;
   } zcm_flags_t;

   // enable vector layout: timeout enables low, crossing enables high
   function automatic int unsigned tmo_en_bit(input int unsigned ph);
      return ph;
   endfunction

   function automatic int unsigned zc_en_bit(input int unsigned ph, input int unsigned nph);
      return nph + ph;
   endfunction
endpackage

// File: rtl/zcm_prescaler.sv
module zcm_prescaler #(
   parameter int unsigned PRESCALE = 384
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PW   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

   logic [PW-1:0] div_q;

   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("zcm_prescaler: PRESCALE must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              div_q <= '0;
      else if (div_q == LAST)  div_q <= '0;
      else                     div_q <= div_q + 1'b1;
   end

   assign tick = (div_q == LAST);

   // R10: ticks are never back to back
   a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   // R10: the divider never leaves its range
   a_r10_div_range: assert property (@(posedge clk) disable iff (!rst_n)
      div_q <= LAST);
endmodule

// File: rtl/zcm_phase_lane.sv
module zcm_phase_lane
   import zcm_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned TMO_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                sample_vld,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic                sel,
   input  logic [TMO_W-1:0]    tmo_reload,
   input  logic                stat_clr,
   output zcm_flags_t          flags
);
   localparam logic [TMO_W-1:0] CNT_INIT = '1;
   localparam logic [TMO_W-1:0] CNT_ONE  = TMO_W'(1);

   logic             prev_neg_q;
   logic [TMO_W-1:0] cnt_q;
   logic             zc_q;
   logic             tmo_q;
   logic             cur_neg;
   logic             xing;
   logic             expire;

   generate
      if (SAMPLE_W < 2) begin : g_bad_sw
         $error("zcm_phase_lane: SAMPLE_W must be at least 2");
      end
      if (TMO_W < 2) begin : g_bad_tw
         $error("zcm_phase_lane: TMO_W must be at least 2");
      end
   endgenerate

   assign cur_neg = sample[SAMPLE_W-1];
   assign xing    = sample_vld && sel && prev_neg_q && !cur_neg;
   assign expire  = sel && !xing && tick && (cnt_q == CNT_ONE);

   // sign history follows every valid sample, selected or not
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prev_neg_q <= 1'b0;
      else if (sample_vld) prev_neg_q <= cur_neg;
   end

   // watchdog: parked on reload while out of service, held at zero once expired
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= CNT_INIT;
      else if (!sel || xing)           cnt_q <= tmo_reload;
      else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   // sticky flags, a fresh event beats the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zc_q  <= 1'b0;
         tmo_q <= 1'b0;
      end else begin
         if (xing)          zc_q <= 1'b1;
         else if (stat_clr) zc_q <= 1'b0;
         if (expire)        tmo_q <= 1'b1;
         else if (stat_clr) tmo_q <= 1'b0;
      end
   end

   assign flags.zc  = zc_q;
   assign flags.tmo = tmo_q | ~sel;

   // R4: a timeout only rises when the counter has reached zero
   a_r4_tmo_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_q) |-> (cnt_q == '0));
   // R5: a counter parked at zero leaves zero only through a reload
   a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && cnt_q == '0) |=> (cnt_q == '0 || cnt_q == $past(tmo_reload)));
   // R6: a crossing leaves the counter holding the reload value
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      xing |=> (cnt_q == $past(tmo_reload)));
   // R7: a clear with no coincident event empties both sticky bits
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !xing && !expire) |=> (!zc_q && !tmo_q));
   // R3: no crossing is recorded while out of service
   a_r3_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !zc_q) |=> !zc_q);
endmodule

// File: rtl/zcm_irq_merge.sv
module zcm_irq_merge
   import zcm_pkg::*;
#(
   parameter int unsigned NUM_PHASE = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_PHASE-1:0]   zc_vec,
   input  logic [NUM_PHASE-1:0]   tmo_vec,
   input  logic [2*NUM_PHASE-1:0] irq_en,
   output logic                   irq_n
);
   logic [2*NUM_PHASE-1:0] src;

   generate
      for (genvar k = 0; k < NUM_PHASE; k++) begin : g_src
         assign src[tmo_en_bit(k)]           = tmo_vec[k];
         assign src[zc_en_bit(k, NUM_PHASE)] = zc_vec[k];
      end
   endgenerate

   assign irq_n = ~|(src & irq_en);

   // R8: with every enable low the request stays inactive
   a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> irq_n);
   // R8: with no flag raised the request stays inactive
   a_r8_irq_noflag: assert property (@(posedge clk) disable iff (!rst_n)
      (zc_vec == '0 && tmo_vec == '0) |-> irq_n);
endmodule

// File: rtl/zc_timeout_monitor.sv
module zc_timeout_monitor
   import zcm_pkg::*;
#(
   parameter int unsigned NUM_PHASE = 3,
   parameter int unsigned SAMPLE_W  = 16,
   parameter int unsigned TMO_W     = 16,
   parameter int unsigned PRESCALE  = 384
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            sample_vld,
   input  logic [NUM_PHASE*SAMPLE_W-1:0]   sample_bus,
   input  logic [NUM_PHASE-1:0]            phase_sel,
   input  logic [TMO_W-1:0]                tmo_reload,
   input  logic [2*NUM_PHASE-1:0]          irq_en,
   input  logic                            stat_clr,
   output logic [NUM_PHASE-1:0]            zc_flag,
   output logic [NUM_PHASE-1:0]            tmo_flag,
   output logic                            irq_n
);
   logic       tick;
   zcm_flags_t lane_flags [NUM_PHASE];

   generate
      if (NUM_PHASE < 1) begin : g_bad_nph
         $error("zc_timeout_monitor: NUM_PHASE must be at least 1");
      end
   endgenerate

   zcm_prescaler #(.PRESCALE(PRESCALE)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   generate
      for (genvar p = 0; p < NUM_PHASE; p++) begin : g_lane
         zcm_phase_lane #(.SAMPLE_W(SAMPLE_W), .TMO_W(TMO_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .sample_vld (sample_vld),
            .sample     (sample_bus[p*SAMPLE_W +: SAMPLE_W]),
            .sel        (phase_sel[p]),
            .tmo_reload (tmo_reload),
            .stat_clr   (stat_clr),
            .flags      (lane_flags[p])
         );
         assign zc_flag[p]  = lane_flags[p].zc;
         assign tmo_flag[p] = lane_flags[p].tmo;
      end
   endgenerate

   zcm_irq_merge #(.NUM_PHASE(NUM_PHASE)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .zc_vec  (zc_flag),
      .tmo_vec (tmo_flag),
      .irq_en  (irq_en),
      .irq_n   (irq_n)
   );

   // R3: an out-of-service phase always reports a timeout
   a_r3_desel_tmo: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_sel == '0) |-> (tmo_flag == '1));
endmodule

// File: tb/zc_timeout_monitor_tb.sv
module zc_timeout_monitor_tb;
   localparam int NPH = 3;
   localparam int SW  = 16;
   localparam int TW  = 16;
   localparam int PS  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sample_vld = 1'b0;
   logic [NPH*SW-1:0] sample_bus = '0;
   logic [NPH-1:0]    phase_sel = '1;
   logic [TW-1:0]     tmo_reload = TW'(1000);
   logic [2*NPH-1:0]  irq_en = '1;
   logic              stat_clr = 1'b0;
   logic [NPH-1:0]    zc_flag;
   logic [NPH-1:0]    tmo_flag;
   logic              irq_n;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   zc_timeout_monitor #(.NUM_PHASE(NPH), .SAMPLE_W(SW), .TMO_W(TW), .PRESCALE(PS)) u_dut (
      .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample_bus(sample_bus),
      .phase_sel(phase_sel), .tmo_reload(tmo_reload), .irq_en(irq_en),
      .stat_clr(stat_clr), .zc_flag(zc_flag), .tmo_flag(tmo_flag), .irq_n(irq_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one valid sample on phase ph, other phases carry zero
   task automatic send(input int ph, input logic signed [SW-1:0] v);
      sample_bus = '0;
      sample_bus[ph*SW +: SW] = v;
      sample_vld = 1'b1;
      @(negedge clk);
      sample_vld = 1'b0;
   endtask

   task automatic clr();
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic signed [SW-1:0] vals [7];
      vals[0] = -16'sd32768; vals[1] = -16'sd5; vals[2] = -16'sd1; vals[3] = 16'sd0;
      vals[4] = 16'sd1;      vals[5] = 16'sd5;  vals[6] = 16'sd32767;

      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 zc", 32'(zc_flag), 0);
      chk("R1 tmo", 32'(tmo_flag), 0);
      chk("R1 irq_n", 32'(irq_n), 1);

      // R9: counter starts at all ones, no timeout after 25 ticks
      idle(200);
      chk("R9 no early timeout", 32'(tmo_flag), 0);

      // R2: sweep every sign pair on every phase
      for (int ph = 0; ph < NPH; ph++) begin
         for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 7; b++) begin
               send(ph, vals[a]);
               clr();
               send(ph, vals[b]);
               chk($sformatf("R2 ph%0d %0d->%0d", ph, vals[a], vals[b]), 32'(zc_flag),
                   ((vals[a] < 0) && (vals[b] >= 0)) ? (32'd1 << ph) : 32'd0);
            end
         end
      end

      // R4: timeout window bounds, reload 5
      tmo_reload = TW'(5);
      for (int ph = 0; ph < NPH; ph++) begin
         send(ph, -16'sd3);
         send(ph, 16'sd3);
         clr();
         idle(29);
         chk($sformatf("R4 ph%0d not early", ph), 32'(tmo_flag[ph]), 0);
         idle(11);
         chk($sformatf("R4 ph%0d expired", ph), 32'(tmo_flag[ph]), 1);
         // R5: flag stays until cleared, counter parked, no refire
         idle(20);
         chk($sformatf("R5 ph%0d held", ph), 32'(tmo_flag[ph]), 1);
         clr();
         idle(3 * PS);
         chk($sformatf("R5 ph%0d no refire", ph), 32'(tmo_flag[ph]), 0);
      end

      // R6: crossings every 20 cycles keep phase 0 alive
      clr();
      for (int i = 0; i < 10; i++) begin
         send(0, -16'sd100);
         send(0, 16'sd100);
         idle(18);
      end
      chk("R6 rearm phase0", 32'(tmo_flag[0]), 0);

      // R7: crossing in the same cycle as clear survives
      tmo_reload = TW'(1000);
      send(1, -16'sd7);
      sample_bus = '0;
      sample_bus[1*SW +: SW] = 16'sd7;
      sample_vld = 1'b1;
      stat_clr   = 1'b1;
      @(negedge clk);
      sample_vld = 1'b0;
      stat_clr   = 1'b0;
      chk("R7 set beats clear", 32'(zc_flag), 32'b010);
      clr();
      chk("R7 clear all zc", 32'(zc_flag), 0);
      chk("R7 clear all tmo", 32'(tmo_flag), 0);

      // R3: deselect phase 2
      phase_sel = 3'b011;
      @(negedge clk);
      chk("R3 forced tmo", 32'(tmo_flag), 32'b100);
      send(2, -16'sd9);
      send(2, 16'sd9);
      chk("R3 no crossing", 32'(zc_flag), 0);
      clr();
      chk("R3 clear ignored", 32'(tmo_flag[2]), 1);
      phase_sel = 3'b111;
      @(negedge clk);
      chk("R3 reselect", 32'(tmo_flag[2]), 0);

      // R8: enable mapping on phase 0
      clr();
      irq_en = '0;
      send(0, -16'sd4);
      send(0, 16'sd4);
      chk("R8 masked", 32'(irq_n), 1);
      irq_en = 6'b001000;
      @(negedge clk);
      chk("R8 zc enable", 32'(irq_n), 0);
      irq_en = 6'b000001;
      @(negedge clk);
      chk("R8 tmo enable only", 32'(irq_n), 1);
      phase_sel = 3'b110;
      @(negedge clk);
      chk("R8 forced tmo irq", 32'(irq_n), 0);
      phase_sel = 3'b111;
      irq_en = 6'b001000;
      clr();
      chk("R8 cleared", 32'(irq_n), 1);

      // R10: one-tick window with reload 1
      tmo_reload = TW'(1);
      send(0, -16'sd2);
      send(0, 16'sd2);
      clr();
      idle(PS + 1);
      chk("R10 single tick", 32'(tmo_flag[0]), 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule